// File: doc/BRIEF.md
# Bit Mask Test-and-Set Sequencer

This block carries out one indivisible test-and-set on a data word, so that a processor core can claim a hardware semaphore. A command gives a bit mask, a target kind and either a memory address or a register index. The block reads the target and checks whether every masked bit is already one. It then writes back the read word with all masked bits forced to one. At the end it reports a test flag. A clear flag means the semaphore was free and this operation now holds it. A set flag means the claim failed and software should try again.

For a memory target, the read and the write go out over a single-master request interface. A lock output stays high from the read address phase through the write address phase, which tells the arbiter to keep other masters out between the two accesses. The memory side returns a write-success level during the write data phase. If it reports that the write was not exclusive, the flag is forced high. For a register target, the block uses a combinational register-file read port and a write port, and that write always counts as successful.

Top module: `bmts_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, busy, done, mem_req, mem_we, mem_lock and rf_we are all 0.
- R2: A command is accepted only on a clock edge where busy is 0 and cmd_valid is 1. busy is 1 from the next cycle until the cycle after the done pulse. cmd_valid while busy has no effect on the address, the data or the number of done pulses.
- R3: With cmd_tgt = 1 (memory), the cycle after acceptance is the read address phase (mem_req=1, mem_we=0, mem_addr = command address). The next cycle is the read data phase, in which mem_rdata is sampled. Next comes the write address phase (mem_req=1, mem_we=1, same address), and then the write data phase.
- R4: mem_lock is 1 without a gap through the read address, read data and write address phases. It is 0 in the write data phase and whenever the block is idle.
- R5: In the write data phase, the written word (mem_wdata or rf_wdata) equals the read word OR the mask.
- R6: mem_ok is sampled only in the memory write data phase, where 0 means the write failed. The final flag is 1 if (read & mask) == mask or the write failed, and 0 otherwise.
- R7: done is high for exactly one cycle, the cycle after the write data phase. t_flag is valid in that cycle, and busy is 0 in the cycle that follows.
- R8: With cmd_tgt = 0 (register), rf_raddr holds the command index in the cycle after acceptance (the read cycle). In the next cycle rf_we=1 with rf_waddr set to the same index. The write counts as successful. mem_req and mem_lock stay 0 throughout.
- R9: A mask of zero counts as all bits set, so the flag is 1 and the word is written back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_tgt | input | 1 | Target kind: 1 memory, 0 register |
| cmd_mask | input | DATA_W | Bits to test and set |
| cmd_addr | input | ADDR_W | Memory address of the target |
| cmd_reg | input | REG_W | Register index of the target |
| busy | output | 1 | Operation in progress; commands held off |
| done | output | 1 | One-cycle completion pulse |
| t_flag | output | 1 | Test flag, valid with done |
| mem_req | output | 1 | Memory address phase |
| mem_we | output | 1 | Address phase is a write |
| mem_lock | output | 1 | Keep other masters off the bus |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data (write data phase) |
| mem_rdata | input | DATA_W | Read data (read data phase) |
| mem_ok | input | 1 | Write exclusive and successful (write data phase) |
| rf_raddr | output | REG_W | Register read index |
| rf_rdata | input | DATA_W | Register read data, combinational |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | REG_W | Register write index |
| rf_wdata | output | DATA_W | Register write data |

## Verification
The assertions assume a memory with no wait states. Read data must be valid in the cycle right after the read address phase, and mem_ok must be meaningful in the cycle after the write address phase. The bench meets this by driving mem_rdata and mem_ok at exactly those cycles. Outside those windows it drives deliberately misleading values, such as the opposite mem_ok level in the write address phase, which shows that only the intended cycle is sampled. Random masks, data and write outcomes come from a fixed seed and are mixed with zero, all-ones and single-bit masks. One operation also raises cmd_valid while busy.

// File: rtl/bmts_pkg.sv
// Shared types for the test-and-set sequencer.
// Assumes: nothing; types only.
package bmts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ADDR = 3'd1,
        ST_RD_DATA = 3'd2,
        ST_WR_ADDR = 3'd3,
        ST_WR_DATA = 3'd4,
        ST_DONE    = 3'd5
    } bmts_state_e;

    typedef enum logic {
        TGT_REG = 1'b0,
        TGT_MEM = 1'b1
    } bmts_tgt_e;
endpackage

// File: rtl/bmts_merge.sv
// Tests whether all masked bits of a word are set and forms the merged word.
// Assumes: purely combinational; a zero mask counts as all set.
module bmts_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] mask,
    output logic              all_set,
    output logic [DATA_W-1:0] merged
);
    localparam int MSB = DATA_W - 1;

    logic [MSB:0] miss;

    // Per-bit test and merge.
    for (genvar i = 0; i <= MSB; i++) begin : g_bit
        assign miss[i]   = mask[i] & ~rd_word[i];
        assign merged[i] = mask[i] | rd_word[i];
    end

    // All set when no masked bit is missing.
    assign all_set = ~|miss;
endmodule

// File: rtl/bmts_ctrl.sv
// Sequencing state machine for one test-and-set operation.
// Assumes: memory data phase always follows its address phase by one cycle.
module bmts_ctrl
    import bmts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_tgt,
    output bmts_state_e state,
    output bmts_tgt_e   tgt_q,
    output logic        accept
);
    bmts_state_e state_d;

    assign accept = (state == ST_IDLE) && cmd_valid;

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_d = cmd_tgt ? ST_RD_ADDR : ST_RD_DATA;
            ST_RD_ADDR: state_d = ST_RD_DATA;
            ST_RD_DATA: state_d = (tgt_q == TGT_MEM) ? ST_WR_ADDR : ST_WR_DATA;
            ST_WR_ADDR: state_d = ST_WR_DATA;
            ST_WR_DATA: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tgt_q <= TGT_REG;
        end else begin
            state <= state_d;
            if (accept) tgt_q <= cmd_tgt ? TGT_MEM : TGT_REG;
        end
    end

    a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state != ST_IDLE));
    a_r7_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
    a_r3_mem_read_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ADDR) |=> (state == ST_RD_DATA));
endmodule

// File: rtl/bmts_seq.sv
// Top of the bit mask test-and-set sequencer: captures a command, runs a
// locked read-modify-write on memory or a register, reports the test flag.
// Assumes: zero-wait-state memory; register read port is combinational.
module bmts_seq
    import bmts_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_tgt,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [REG_W-1:0]  cmd_reg,
    output logic              busy,
    output logic              done,
    output logic              t_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ok,
    output logic [REG_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    bmts_state_e       state;
    bmts_tgt_e         tgt_q;
    logic              accept;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  reg_q;
    logic              t_q;
    logic              all_set;
    logic [DATA_W-1:0] merged;
    logic              is_mem;
    logic              wr_fail;

    bmts_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_tgt   (cmd_tgt),
        .state     (state),
        .tgt_q     (tgt_q),
        .accept    (accept)
    );

    bmts_merge #(.DATA_W(DATA_W)) u_merge (
        .rd_word (rd_q),
        .mask    (mask_q),
        .all_set (all_set),
        .merged  (merged)
    );

    assign is_mem  = (tgt_q == TGT_MEM);
    assign wr_fail = is_mem && !mem_ok;

    // Command capture, read capture and flag computation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            addr_q <= '0;
            reg_q  <= '0;
            rd_q   <= '0;
            t_q    <= 1'b0;
        end else begin
            if (accept) begin
                mask_q <= cmd_mask;
                addr_q <= cmd_addr;
                reg_q  <= cmd_reg;
            end
            if (state == ST_RD_DATA) rd_q <= is_mem ? mem_rdata : rf_rdata;
            if (state == ST_WR_DATA) t_q <= all_set | wr_fail;
        end
    end

    // Port decode from state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        t_flag    = t_q;
        mem_req   = (state == ST_RD_ADDR) || (state == ST_WR_ADDR);
        mem_we    = (state == ST_WR_ADDR);
        mem_lock  = is_mem && ((state == ST_RD_ADDR) || (state == ST_RD_DATA)
                               || (state == ST_WR_ADDR));
        mem_addr  = addr_q;
        mem_wdata = merged;
        rf_raddr  = reg_q;
        rf_we     = !is_mem && (state == ST_WR_DATA);
        rf_waddr  = reg_q;
        rf_wdata  = merged;
    end

    a_r3_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);
    a_r4_lock_starts_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> (mem_req && !mem_we));
    a_r4_lock_ends_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_we));
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !mem_req) |=> (mem_req && mem_we));
    a_r5_wdata_merge: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_we) |-> (mem_wdata == ($past(mem_rdata, 2) | mask_q)));
    a_r6_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we) && !mem_ok) |=> (done && t_flag));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r8_reg_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!mem_req && !mem_lock));
endmodule

// File: tb/bmts_seq_tb.sv
module bmts_seq_tb;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_tgt = 1'b0;
    logic [DW-1:0] cmd_mask = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [RW-1:0] cmd_reg = '0;
    logic          busy, done, t_flag, mem_req, mem_we, mem_lock, rf_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, rf_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] rf_rdata = '0;
    logic          mem_ok = 1'b0;
    logic [RW-1:0] rf_raddr, rf_waddr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bmts_seq #(.DATA_W(DW), .ADDR_W(AW), .REG_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tgt(cmd_tgt),
        .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_reg(cmd_reg),
        .busy(busy), .done(done), .t_flag(t_flag), .mem_req(mem_req),
        .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ok(mem_ok),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    function automatic logic exp_flag(logic [DW-1:0] rd, logic [DW-1:0] m, logic ok);
        return ((rd & m) == m) || !ok;
    endfunction

    task automatic check(input bit cond, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Memory-target operation; poke drives cmd_valid while busy (R2).
    task automatic mem_op(input logic [DW-1:0] m, input logic [AW-1:0] a,
                          input logic [DW-1:0] rd, input logic ok, input bit poke);
        logic [DW-1:0] wexp = rd | m;
        logic          texp = exp_flag(rd, m, ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tgt = 1'b1; cmd_mask = m; cmd_addr = a;
        @(negedge clk);                       // read address phase
        cmd_valid = 1'b0; cmd_mask = ~m; cmd_addr = ~a;
        check(mem_req && !mem_we && mem_lock && busy, "R3 read addr phase",
              {mem_req, mem_we, mem_lock, busy}, 4'b1011);
        check(mem_addr == a, "R3 read address", mem_addr, a);
        mem_rdata = rd;
        @(negedge clk);                       // read data phase
        check(mem_lock && !mem_req, "R4 lock in read data", {mem_lock, mem_req}, 2'b10);
        if (poke) begin cmd_valid = 1'b1; cmd_tgt = 1'b1; cmd_addr = ~a; end
        @(negedge clk);                       // write address phase
        mem_rdata = ~rd;
        mem_ok = ~ok;
        check(mem_req && mem_we && mem_lock, "R3 write addr phase",
              {mem_req, mem_we, mem_lock}, 3'b111);
        check(mem_addr == a, "R2 address held while busy", mem_addr, a);
        @(negedge clk);                       // write data phase
        mem_ok = ok;
        check(!mem_lock && !mem_req, "R4 lock off in write data", {mem_lock, mem_req}, 2'b00);
        check(mem_wdata == wexp, "R5 merged write data", mem_wdata, wexp);
        @(negedge clk);                       // done
        check(done && t_flag == texp, "R6 flag with done", {done, t_flag}, {1'b1, texp});
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!done && !busy, "R7 single done then idle", {done, busy}, 2'b00);
    endtask

    // Register-target operation.
    task automatic reg_op(input logic [DW-1:0] m, input logic [RW-1:0] r,
                          input logic [DW-1:0] rd);
        logic [DW-1:0] wexp = rd | m;
        logic          texp = exp_flag(rd, m, 1'b1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tgt = 1'b0; cmd_mask = m; cmd_reg = r;
        mem_ok = 1'b0;
        @(negedge clk);                       // read cycle
        cmd_valid = 1'b0; cmd_reg = ~r;
        check(rf_raddr == r, "R8 register read index", rf_raddr, r);
        check(!mem_req && !mem_lock && busy, "R8 no bus on read",
              {mem_req, mem_lock, busy}, 3'b001);
        rf_rdata = rd;
        @(negedge clk);                       // write cycle
        rf_rdata = ~rd;
        check(rf_we && rf_waddr == r && !mem_lock, "R8 register write",
              {rf_we, rf_waddr}, {1'b1, r});
        check(rf_wdata == wexp, "R5 register merged data", rf_wdata, wexp);
        @(negedge clk);                       // done
        check(done && t_flag == texp, "R8 flag ignores mem_ok", {done, t_flag}, {1'b1, texp});
        @(negedge clk);
        check(!busy && !done && !rf_we, "R7 register op idle", {busy, done, rf_we}, 3'b000);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !mem_we && !mem_lock && !rf_we,
              "R1 reset state", {busy, done, mem_req, mem_we, mem_lock, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req && !mem_lock && !rf_we,
              "R1 after reset", {busy, done, mem_req, mem_lock, rf_we}, 0);

        // Directed corners.
        mem_op(16'h0004, 16'h1000, 16'h0000, 1'b1, 1'b0);   // R6 free, claimed: flag 0
        mem_op(16'h0004, 16'h1000, 16'h0004, 1'b1, 1'b0);   // R6 already taken
        mem_op(16'h0004, 16'h1002, 16'h0000, 1'b0, 1'b0);   // R6 write failed
        mem_op(16'h0000, 16'h2000, 16'hA5A5, 1'b1, 1'b0);   // R9 zero mask
        mem_op(16'hFFFF, 16'h3000, 16'hFFFE, 1'b1, 1'b1);   // R2 poke while busy
        reg_op(16'h0000, 4'd3, 16'h1234);                   // R9 zero mask on register
        reg_op(16'h8000, 4'd15, 16'h0001);
        reg_op(16'h8000, 4'd1, 16'h8000);

        // Random mix.
        for (int i = 0; i < 60; i++) begin
            logic [DW-1:0] m  = ($urandom % 2) ? (16'h1 << ($urandom % DW)) : DW'($urandom);
            logic [DW-1:0] rd = DW'($urandom);
            if ($urandom % 3 == 0) rd = rd | m;
            if ($urandom % 3 != 0)
                mem_op(m, AW'($urandom), rd, ($urandom % 4) != 0, ($urandom % 5) == 0);
            else
                reg_op(m, RW'($urandom), rd);
        end

        summary();
        $finish;
    end
endmodule